// File: doc/BRIEF.md
# Dual-View Crypto Event Interrupt Controller

This block sits beside a cipher engine's DMA path. It records three completion events, each arriving as a one-cycle pulse: the context has been loaded, the last input word has been accepted, and the last output word has been written. Software sees these events through two independent register views on a 32-bit register bus.

The wrapper view has four registers: a mask, a raw status, a masked status and a write-one acknowledge. The engine view is a status/enable pair, and it alone drives the interrupt output. The two views place the events at different bit positions, and their enable defaults are opposite. Each view has to be cleared on its own.

Writes take effect only when all four byte enables are set. Reads are combinational from the byte address. Offsets are 0x00 for the wrapper mask, 0x04 for raw status, 0x08 for masked status, 0x0C for acknowledge, 0x10 for engine status and 0x14 for engine enable. Any other offset reads zero.

Top module: `cirq_dual_view`

## Requirements
- R1: After reset, the wrapper mask reads 0x0000000D. Raw status, masked status, engine status and engine enable all read 0, and `irq_o` is low.
- R2: An event pulse sets its raw bit in the wrapper view, readable from the next cycle, whatever the mask holds. Context is bit 0, input done is bit 2 and output done is bit 3.
- R3: The masked status word equals the raw status word ANDed with the wrapper mask.
- R4: A full write to the wrapper mask stores bits 0, 2 and 3. Every other bit of the mask reads zero.
- R5: Writing 1 to a bit of the acknowledge register clears that raw bit. Writing 0 to a bit leaves it unchanged. The acknowledge register always reads zero.
- R6: An event pulse sets its engine status bit: context is bit 0, input done is bit 1 and output done is bit 2. Writing 1 to an engine status bit clears it.
- R7: A full write to the engine enable register stores bits 2 to 0. All other bits read zero.
- R8: `irq_o` is high exactly when some engine status bit and its enable bit are both set.
- R9: If an event and a write-one clear hit the same bit in the same cycle, the bit stays set. This holds in both views.
- R10: A write with any byte enable low changes no register.
- R11: Clearing a bit in one view leaves the other view's status unchanged.
- R12: Offsets outside the six listed registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_be | input | 4 | Byte enables; a write needs all four set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ev_ctx | input | 1 | Pulse: context load done |
| ev_din | input | 1 | Pulse: last input word accepted |
| ev_dout | input | 1 | Pulse: last output word written |
| irq_o | output | 1 | Interrupt from the engine view |

## Verification
The assertions assume that event inputs and bus controls are clean, synchronous levels sampled once per clock. They also assume that an enable write can change the interrupt in the cycle after an event, which is why the interrupt property excludes enable writes. The stimulus drives every input half a cycle away from the sampling edge and holds each event high for exactly one cycle. A sweep over every mask value, enable value and event combination then compares each register and the interrupt output with values computed arithmetically from the bit maps.

// File: rtl/cirq_pkg.sv
// Shared constants for the dual-view interrupt controller.
// Assumes event index 0 = context, 1 = input done, 2 = output done.
package cirq_pkg;
    localparam int NUM_EV  = 3;
    localparam int DATA_W  = 32;

    // Byte offsets of the registers
    localparam int OFF_WMASK = 'h00;
    localparam int OFF_WRAW  = 'h04;
    localparam int OFF_WMSK  = 'h08;
    localparam int OFF_WACK  = 'h0C;
    localparam int OFF_ESTAT = 'h10;
    localparam int OFF_EEN   = 'h14;

    // Bit position of an event in the wrapper view
    function automatic int wrap_pos(input int k);
        case (k)
            0:       return 0;
            1:       return 2;
            default: return 3;
        endcase
    endfunction

    // Bit position of an event in the engine view
    function automatic int eng_pos(input int k);
        return k;
    endfunction
endpackage

// File: rtl/cirq_wrap_view.sv
// Wrapper view: mask (reset enabled), raw status, masked status, write-one ack.
// Assumes: ev_i are one-cycle pulses; mask_we/ack_we are already qualified full writes;
// wbits_i[k] is the write data bit at the wrapper position of event k.
module cirq_wrap_view #(
    parameter int NUM_EV = cirq_pkg::NUM_EV,
    parameter int DATA_W = cirq_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              mask_we,
    input  logic              ack_we,
    input  logic [NUM_EV-1:0] wbits_i,
    output logic [DATA_W-1:0] mask_rd,
    output logic [DATA_W-1:0] raw_rd,
    output logic [DATA_W-1:0] msk_rd
);
    logic [NUM_EV-1:0] mask_q;
    logic [NUM_EV-1:0] raw_q;

    // Mask storage: resets to all enabled, loaded on a full write
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= wbits_i;
    end

    // Raw status: an event sets its bit, and an ack clears it unless an event arrives in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            for (int k = 0; k < NUM_EV; k++) begin
                if (ev_i[k])                     raw_q[k] <= 1'b1;
                else if (ack_we && wbits_i[k])   raw_q[k] <= 1'b0;
            end
        end
    end

    // Spread the event bits onto their wrapper positions for reading
    always_comb begin
        mask_rd = '0;
        raw_rd  = '0;
        msk_rd  = '0;
        for (int k = 0; k < NUM_EV; k++) begin
            mask_rd[cirq_pkg::wrap_pos(k)] = mask_q[k];
            raw_rd[cirq_pkg::wrap_pos(k)]  = raw_q[k];
            msk_rd[cirq_pkg::wrap_pos(k)]  = raw_q[k] & mask_q[k];
        end
    end

    for (genvar g = 0; g < NUM_EV; g++) begin : g_chk
        // R2
        ev_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[g] |=> raw_q[g]);
        // R5
        ack_clears_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_we && wbits_i[g] && !ev_i[g]) |=> !raw_q[g]);
    end
endmodule

// File: rtl/cirq_eng_view.sv
// Engine view: status with write-one clear, enable (reset disabled), interrupt output.
// Assumes: ev_i are one-cycle pulses; stat_we/en_we are already qualified full writes;
// wbits_i[k] is the write data bit at the engine position of event k.
module cirq_eng_view #(
    parameter int NUM_EV = cirq_pkg::NUM_EV,
    parameter int DATA_W = cirq_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              stat_we,
    input  logic              en_we,
    input  logic [NUM_EV-1:0] wbits_i,
    output logic [DATA_W-1:0] stat_rd,
    output logic [DATA_W-1:0] en_rd,
    output logic              irq_o
);
    logic [NUM_EV-1:0] stat_q;
    logic [NUM_EV-1:0] en_q;

    // Enable storage: resets to all disabled
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wbits_i;
    end

    // Status: an event sets its bit, and a write-one clears it unless an event arrives in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            for (int k = 0; k < NUM_EV; k++) begin
                if (ev_i[k])                     stat_q[k] <= 1'b1;
                else if (stat_we && wbits_i[k])  stat_q[k] <= 1'b0;
            end
        end
    end

    // Interrupt: any enabled status bit
    assign irq_o = |(stat_q & en_q);

    // Spread the bits onto their engine positions for reading
    always_comb begin
        stat_rd = '0;
        en_rd   = '0;
        for (int k = 0; k < NUM_EV; k++) begin
            stat_rd[cirq_pkg::eng_pos(k)] = stat_q[k];
            en_rd[cirq_pkg::eng_pos(k)]   = en_q[k];
        end
    end

    for (genvar g = 0; g < NUM_EV; g++) begin : g_chk
        // R6
        ev_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[g] |=> stat_q[g]);
        // R8
        enabled_ev_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_i[g] && en_q[g] && !en_we) |=> irq_o);
    end
endmodule

// File: rtl/cirq_rd_mux.sv
// Read multiplexer: selects one register word by byte address; unmapped offsets read zero.
// Assumes the acknowledge offset has no storage and always returns zero.
module cirq_rd_mux #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = cirq_pkg::DATA_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wmask_i,
    input  logic [DATA_W-1:0] wraw_i,
    input  logic [DATA_W-1:0] wmsk_i,
    input  logic [DATA_W-1:0] estat_i,
    input  logic [DATA_W-1:0] een_i,
    output logic [DATA_W-1:0] rdata_o
);
    // Address decode of the read data
    always_comb begin
        rdata_o = '0;
        if      (addr_i == ADDR_W'(cirq_pkg::OFF_WMASK)) rdata_o = wmask_i;
        else if (addr_i == ADDR_W'(cirq_pkg::OFF_WRAW))  rdata_o = wraw_i;
        else if (addr_i == ADDR_W'(cirq_pkg::OFF_WMSK))  rdata_o = wmsk_i;
        else if (addr_i == ADDR_W'(cirq_pkg::OFF_ESTAT)) rdata_o = estat_i;
        else if (addr_i == ADDR_W'(cirq_pkg::OFF_EEN))   rdata_o = een_i;
    end
endmodule

// File: rtl/cirq_dual_view.sv
// Top: decodes full-word writes and routes the three event pulses into the
// wrapper view and the engine view. Reads are combinational.
// Assumes events are synchronous one-cycle pulses and the bus is 32 bits wide.
module cirq_dual_view #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_ctx,
    input  logic              ev_din,
    input  logic              ev_dout,
    output logic              irq_o
);
    localparam int NUM_EV = cirq_pkg::NUM_EV;
    localparam int DATA_W = cirq_pkg::DATA_W;

    logic [NUM_EV-1:0] ev;
    logic              wr_full;
    logic [NUM_EV-1:0] w_bits;
    logic [NUM_EV-1:0] e_bits;
    logic [DATA_W-1:0] w_mask_word, w_raw_word, w_msk_word, e_stat_word, e_en_word;
    logic              unused_wdata;

    assign ev      = {ev_dout, ev_din, ev_ctx};
    assign wr_full = bus_wr && (&bus_be);
    assign unused_wdata = ^bus_wdata;

    // Pick the write data bits at each view's event positions
    always_comb begin
        for (int k = 0; k < NUM_EV; k++) begin
            w_bits[k] = bus_wdata[cirq_pkg::wrap_pos(k)];
            e_bits[k] = bus_wdata[cirq_pkg::eng_pos(k)];
        end
    end

    cirq_wrap_view #(.NUM_EV(NUM_EV), .DATA_W(DATA_W)) u_wrap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev),
        .mask_we (wr_full && bus_addr == ADDR_W'(cirq_pkg::OFF_WMASK)),
        .ack_we  (wr_full && bus_addr == ADDR_W'(cirq_pkg::OFF_WACK)),
        .wbits_i (w_bits),
        .mask_rd (w_mask_word),
        .raw_rd  (w_raw_word),
        .msk_rd  (w_msk_word)
    );

    cirq_eng_view #(.NUM_EV(NUM_EV), .DATA_W(DATA_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev),
        .stat_we (wr_full && bus_addr == ADDR_W'(cirq_pkg::OFF_ESTAT)),
        .en_we   (wr_full && bus_addr == ADDR_W'(cirq_pkg::OFF_EEN)),
        .wbits_i (e_bits),
        .stat_rd (e_stat_word),
        .en_rd   (e_en_word),
        .irq_o   (irq_o)
    );

    cirq_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .addr_i  (bus_addr),
        .wmask_i (w_mask_word),
        .wraw_i  (w_raw_word),
        .wmsk_i  (w_msk_word),
        .estat_i (e_stat_word),
        .een_i   (e_en_word),
        .rdata_o (bus_rdata)
    );

    // R10
    partial_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !(&bus_be)) |=> ($stable(w_mask_word) && $stable(e_en_word)));
endmodule

// File: tb/cirq_dual_view_test.sv
`timescale 1ns/1ps
module cirq_dual_view_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_ctx = 1'b0, ev_din = 1'b0, ev_dout = 1'b0;
    logic        irq_o;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    localparam logic [5:0] A_WMASK = 6'h00, A_WRAW = 6'h04, A_WMSK = 6'h08,
                           A_WACK = 6'h0C, A_ESTAT = 6'h10, A_EEN = 6'h14, A_NONE = 6'h18;

    cirq_dual_view #(.ADDR_W(6)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_ctx(ev_ctx), .ev_din(ev_din),
        .ev_dout(ev_dout), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    // Wrapper-view image of a 3-bit event set: bits 0,2,3
    function automatic logic [31:0] wmap(input logic [2:0] e);
        return 32'(e[0]) | (32'(e[1]) << 2) | (32'(e[2]) << 3);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        @(negedge clk);
        #1;
        chk(req, {31'd0, irq_o}, {31'd0, exp});
    endtask

    // One bus write, optionally with events in the same cycle
    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be,
                      input logic [2:0] e);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        {ev_dout, ev_din, ev_ctx} = e;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
        {ev_dout, ev_din, ev_ctx} = 3'b000;
    endtask

    task automatic pulse(input logic [2:0] e);
        @(negedge clk);
        {ev_dout, ev_din, ev_ctx} = e;
        @(negedge clk);
        {ev_dout, ev_din, ev_ctx} = 3'b000;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd("R1 mask", A_WMASK, 32'hD);
        rd("R1 raw", A_WRAW, 32'h0);
        rd("R1 masked", A_WMSK, 32'h0);
        rd("R1 estat", A_ESTAT, 32'h0);
        rd("R1 een", A_EEN, 32'h0);
        chk_irq("R1 irq", 1'b0);

        // R4 R7 reserved bits
        wr(A_WMASK, 32'hFFFF_FFFF, 4'hF, 3'b000);
        rd("R4 mask all ones", A_WMASK, 32'hD);
        wr(A_EEN, 32'hFFFF_FFFF, 4'hF, 3'b000);
        rd("R7 enable all ones", A_EEN, 32'h7);

        // R10 partial byte enables ignored
        for (int b = 0; b < 15; b++) begin
            wr(A_WMASK, 32'h0, 4'(b), 3'b000);
            rd("R10 mask partial", A_WMASK, 32'hD);
            wr(A_EEN, 32'h0, 4'(b), 3'b000);
            rd("R10 enable partial", A_EEN, 32'h7);
        end
        pulse(3'b111);
        wr(A_WACK, 32'hF, 4'h7, 3'b000);
        rd("R10 ack partial", A_WRAW, 32'hD);
        wr(A_ESTAT, 32'h7, 4'hE, 3'b000);
        rd("R10 estat partial", A_ESTAT, 32'h7);

        // R5 ack reads zero, R12 unmapped reads zero
        rd("R5 ack reads zero", A_WACK, 32'h0);
        rd("R12 unmapped", A_NONE, 32'h0);
        rd("R12 unmapped top", 6'h3C, 32'h0);

        // R11 independence of the views
        wr(A_WACK, 32'hD, 4'hF, 3'b000);
        rd("R11 raw cleared", A_WRAW, 32'h0);
        rd("R11 estat kept", A_ESTAT, 32'h7);
        chk_irq("R8 irq held", 1'b1);
        pulse(3'b111);
        wr(A_ESTAT, 32'h7, 4'hF, 3'b000);
        rd("R11 estat cleared", A_ESTAT, 32'h0);
        rd("R11 raw kept", A_WRAW, 32'hD);
        chk_irq("R8 irq low", 1'b0);

        // R9 event wins over same-cycle clear, R5 selective ack
        wr(A_WACK, 32'hD, 4'hF, 3'b001);
        rd("R9 wrap collision", A_WRAW, 32'h1);
        pulse(3'b010);
        wr(A_ESTAT, 32'h7, 4'hF, 3'b010);
        rd("R9 eng collision", A_ESTAT, 32'h2);
        pulse(3'b100);
        wr(A_WACK, 32'h8, 4'hF, 3'b000);
        rd("R5 selective ack", A_WRAW, 32'h5);
        wr(A_WACK, 32'hF, 4'hF, 3'b000);
        wr(A_ESTAT, 32'h7, 4'hF, 3'b000);

        // R2 R3 R6 R8 sweep over mask, enable and events
        for (int m = 0; m < 16; m++) begin
            wr(A_WMASK, 32'(m), 4'hF, 3'b000);
            rd("R4 mask value", A_WMASK, 32'(m) & 32'hD);
            for (int en = 0; en < 8; en++) begin
                wr(A_EEN, 32'(en), 4'hF, 3'b000);
                for (int e = 0; e < 8; e++) begin
                    pulse(3'(e));
                    rd("R2 raw", A_WRAW, wmap(3'(e)));
                    rd("R3 masked", A_WMSK, wmap(3'(e)) & 32'(m) & 32'hD);
                    rd("R6 estat", A_ESTAT, 32'(e));
                    chk_irq("R8 irq", |(3'(e) & 3'(en)));
                    wr(A_WACK, 32'hF, 4'hF, 3'b000);
                    wr(A_ESTAT, 32'h7, 4'hF, 3'b000);
                    rd("R5 raw after ack", A_WRAW, 32'h0);
                    rd("R6 estat after clear", A_ESTAT, 32'h0);
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 190000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule